// File: doc/BRIEF.md
# Card Host Interrupt Status Collector

This block gathers single-cycle event pulses from a storage-card host controller into a 32-bit status word and drives one level interrupt request. Each event position has three bits of state. The status bit records that the event happened. The enable bit decides whether the event may latch into status at all. The signal mask bit decides whether a latched status bit may reach the request line. Software reads the status, enable and mask words from the output ports. It writes them through a small register write port: status clears when ones are written to it, and the enable and mask words are written directly.

Three positions have their own rules. Command-complete is not an event input. It is derived from a falling edge of the command-busy input, and it is withheld when a command timeout was flagged during that command. The two buffer-ready positions remember an unserviced event. After one of them latches, further pulses on that position are ignored until the matching service input arrives. A summary error bit reports whether any bit of the error group is set.

Top module: `isr_host_irq`

## Requirements
- R1: An event whose enable bit is 0 does not set its status bit and raises no request, whatever its mask bit holds.
- R2: An event pulse on an enabled position sets that status bit, and `stat_o` shows it on the cycle after the pulse.
- R3: A write with `wr_sel_i`=0 clears every status bit where `wr_data_i` is 1 and leaves the bits where it is 0. When an event and a clear hit the same bit in the same cycle, the bit ends set.
- R4: `irq_o` is 1 exactly one cycle after any position has status, enable and mask all set. It is 0 after reset.
- R5: Clearing a pending bit's mask bit drops its share of `irq_o` one cycle after the mask write. The status bit stays set.
- R6: A status bit that was cleared is not set again when its mask is restored, and no request follows unless a new pulse arrives.
- R7: Bits 4 and 5 are the buffer-ready positions, serviced by `svc_i[0]` and `svc_i[1]`. Once either position has latched, further pulses on it are ignored until its service input is pulsed. A pulse that arrives together with its service input is accepted.
- R8: Status bit 15 reads 1 exactly when any status bit from 16 to 24 is 1. Events or clear writes aimed at bit 15 have no effect on it.
- R9: Status bit 0 is set on the cycle after `cmd_busy_i` has gone from 1 to 0, provided enable bit 0 is set. There is no event input for bit 0.
- R10: If bit 16 (command timeout) pulses while `cmd_busy_i` is high, or in the same cycle as its fall, bit 0 is not set for that command.
- R11: Only positions 0-5, 8, 10, 15-22, 24, 25, 28 and 29 exist. All other bits of the status, enable and mask words always read 0.
- R12: After reset all three words are zero. `wr_sel_i`=1 writes the enable word, `wr_sel_i`=2 writes the mask word, and `wr_sel_i`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 31 | Event pulses for bit positions 31 down to 1 |
| cmd_busy_i | input | 1 | Command in flight. Its falling edge yields command-complete |
| svc_i | input | 2 | Service pulses for the write-buffer (0) and read-buffer (1) events |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 status clear, 1 enable, 2 mask, 3 none |
| wr_data_i | input | 32 | Write data |
| stat_o | output | 32 | Status word, including the summary bit |
| en_o | output | 32 | Enable word |
| mask_o | output | 32 | Signal mask word |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Four properties are checked on every cycle. No status bit rises without its enable bit. No status bit falls without a clear write. The request always follows the previous cycle's gated status. Command-complete never appears together with a timeout at the command's end. Only the bench's scenarios can show the buffer-ready wait-for-service sequence, the set-over-clear tie, the summary bit's reaction to clear writes, and the fact that a cleared bit stays cleared when its mask returns. These depend on multi-step histories that the properties do not track. The bench sweeps every ordinary position through the disabled, enabled, masked, cleared and restored stages, and compares the words with values computed from the bit index.

// File: rtl/isr_pkg.sv
package isr_pkg;
    localparam int unsigned STAT_W   = 32;
    localparam int unsigned CC_BIT   = 0;
    localparam int unsigned SUM_BIT  = 15;
    localparam int unsigned CTO_BIT  = 16;
    localparam int unsigned ERR_LO   = 16;
    localparam int unsigned ERR_HI   = 24;
    localparam int unsigned BUF_BASE = 4;
    localparam int unsigned NUM_BUF  = 2;

    typedef logic [STAT_W-1:0] vec_t;

    // positions that exist; all others read zero
    localparam vec_t VALID_MASK = 32'h337F_853F;

    typedef enum logic [1:0] {
        SEL_STAT = 2'd0,
        SEL_EN   = 2'd1,
        SEL_MASK = 2'd2,
        SEL_NONE = 2'd3
    } wsel_e;
endpackage

// File: rtl/isr_cfg_regs.sv
module isr_cfg_regs
    import isr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic [1:0] wr_sel_i,
    input  vec_t       wr_data_i,
    output vec_t       en_o,
    output vec_t       mask_o
);
    typedef struct packed {
        vec_t en;
        vec_t mask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i && wr_sel_i == SEL_EN)   cfg_d.en   = wr_data_i & VALID_MASK;
        if (wr_en_i && wr_sel_i == SEL_MASK) cfg_d.mask = wr_data_i & VALID_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign en_o   = cfg_q.en;
    assign mask_o = cfg_q.mask;
endmodule

// File: rtl/isr_cmd_done.sv
module isr_cmd_done (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  logic cto_i,
    output logic done_o
);
    typedef struct packed {
        logic busy;
        logic cto_seen;
    } cmd_t;

    cmd_t cmd_d, cmd_q;
    logic fall, rise;

    always_comb begin
        rise   = !cmd_q.busy && busy_i;
        fall   = cmd_q.busy && !busy_i;
        done_o = fall && !cmd_q.cto_seen && !cto_i;
        cmd_d.busy = busy_i;
        if (rise)      cmd_d.cto_seen = cto_i;
        else if (fall) cmd_d.cto_seen = 1'b0;
        else           cmd_d.cto_seen = cmd_q.cto_seen | cto_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end
endmodule

// File: rtl/isr_status_bank.sv
module isr_status_bank
    import isr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  vec_t               evt_i,
    input  vec_t               en_i,
    input  vec_t               clr_i,
    input  logic [NUM_BUF-1:0] svc_i,
    output vec_t               stat_o
);
    typedef struct packed {
        vec_t               stat;
        logic [NUM_BUF-1:0] wait_svc;
    } bank_t;

    localparam vec_t LATCH_MASK = VALID_MASK & ~(vec_t'(1) << SUM_BIT);

    bank_t bank_d, bank_q;
    logic [NUM_BUF-1:0] blocked;
    vec_t accept;

    for (genvar k = 0; k < NUM_BUF; k++) begin : g_buf
        assign blocked[k] = bank_q.wait_svc[k] && !svc_i[k];
    end

    always_comb begin
        accept = evt_i & en_i & LATCH_MASK & ~(vec_t'(blocked) << BUF_BASE);
        bank_d.stat = (bank_q.stat & ~clr_i) | accept;
        for (int k = 0; k < NUM_BUF; k++) begin
            bank_d.wait_svc[k] = blocked[k] | accept[BUF_BASE + k];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    always_comb begin
        stat_o          = bank_q.stat;
        stat_o[SUM_BIT] = |bank_q.stat[ERR_HI:ERR_LO];
    end
endmodule

// File: rtl/isr_host_irq.sv
module isr_host_irq
    import isr_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [STAT_W-1:1]        evt_i,
    input  logic                     cmd_busy_i,
    input  logic [NUM_BUF-1:0]       svc_i,
    input  logic                     wr_en_i,
    input  logic [1:0]               wr_sel_i,
    input  logic [STAT_W-1:0]        wr_data_i,
    output logic [STAT_W-1:0]        stat_o,
    output logic [STAT_W-1:0]        en_o,
    output logic [STAT_W-1:0]        mask_o,
    output logic                     irq_o
);
    typedef struct packed {
        logic irq;
    } top_t;

    top_t top_d, top_q;
    logic cc_pulse;
    vec_t evt_all;
    vec_t clr_vec;

    isr_cfg_regs i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .en_o      (en_o),
        .mask_o    (mask_o)
    );

    isr_cmd_done i_cmd (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy_i (cmd_busy_i),
        .cto_i  (evt_i[CTO_BIT]),
        .done_o (cc_pulse)
    );

    always_comb begin
        evt_all = {evt_i, cc_pulse};
        clr_vec = (wr_en_i && wr_sel_i == SEL_STAT) ? wr_data_i : '0;
    end

    isr_status_bank i_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_all),
        .en_i   (en_o),
        .clr_i  (clr_vec),
        .svc_i  (svc_i),
        .stat_o (stat_o)
    );

    always_comb begin
        top_d.irq = |(stat_o & en_o & mask_o);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign irq_o = top_q.irq;
endmodule

// File: rtl/isr_host_irq_chk.sv
module isr_host_irq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:1] evt_i,
    input logic        cmd_busy_i,
    input logic        wr_en_i,
    input logic [1:0]  wr_sel_i,
    input logic [31:0] wr_data_i,
    input logic [31:0] stat_o,
    input logic [31:0] en_o,
    input logic [31:0] mask_o,
    input logic        irq_o
);
    localparam logic [31:0] NOT_SUM = ~(32'h1 << 15);

    logic [31:0] clr_seen;
    assign clr_seen = (wr_en_i && wr_sel_i == 2'd0) ? wr_data_i : 32'h0;

    // R1: a status bit may only rise when its enable was set
    p_rise_needs_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_o & ~$past(stat_o) & ~$past(en_o) & NOT_SUM) == 32'h0));

    // R3: a status bit may only fall after a clear write with a one there
    p_fall_needs_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~stat_o & $past(stat_o) & ~$past(clr_seen) & NOT_SUM) == 32'h0));

    // R4: request follows the gated status of the previous cycle
    p_irq_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(stat_o & en_o & mask_o))));

    // R10: timeout at the end of a command blocks command-complete
    p_cto_blocks_cc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i[16] && !cmd_busy_i && $past(cmd_busy_i)) |=> !(stat_o[0] && !$past(stat_o[0])));
endmodule

bind isr_host_irq isr_host_irq_chk i_chk (.*);

// File: tb/test_isr_host_irq.sv
`timescale 1ns/1ps
module test_isr_host_irq;
    localparam logic [31:0] VALID = 32'h337F_853F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:1] evt = '0;
    logic        busy = 1'b0;
    logic [1:0]  svc = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] stat, en, mask;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    isr_host_irq i_isr_host_irq (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .cmd_busy_i(busy), .svc_i(svc),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .stat_o(stat), .en_o(en), .mask_o(mask), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse(input logic [31:0] v);
        evt = v[31:1];
        step();
        evt = '0;
    endtask

    function automatic logic [31:0] expect_of(input int b);
        logic [31:0] e;
        e = 32'h1 << b;
        if (b >= 16 && b <= 24) e = e | (32'h1 << 15);
        return e;
    endfunction

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 reset stat", stat, 32'h0);
        chk("R12 reset en", en, 32'h0);
        chk("R4 reset irq", {31'h0, irq}, 32'h0);
        rst_n = 1'b1;
        step();

        // sweep ordinary positions
        for (int b = 1; b < 30; b++) begin
            if (VALID[b] && b != 4 && b != 5 && b != 15) begin
                wr(2'd1, 32'h0);
                wr(2'd2, 32'hFFFF_FFFF);
                pulse(32'h1 << b);
                chk("R1 disabled no latch", stat, 32'h0);
                step();
                chk("R1 disabled no irq", {31'h0, irq}, 32'h0);
                wr(2'd1, 32'h1 << b);
                pulse(32'h1 << b);
                chk("R2/R8 latch", stat, expect_of(b));
                step();
                chk("R4 irq raised", {31'h0, irq}, 32'h1);
                wr(2'd2, 32'h0);
                step();
                chk("R5 masked irq", {31'h0, irq}, 32'h0);
                chk("R5 status kept", stat, expect_of(b));
                wr(2'd0, 32'h0);
                chk("R3 zero write", stat, expect_of(b));
                wr(2'd0, 32'h1 << b);
                chk("R3 clear", stat, 32'h0);
                wr(2'd2, 32'hFFFF_FFFF);
                step();
                chk("R6 no relatch", stat, 32'h0);
                chk("R6 no irq", {31'h0, irq}, 32'h0);
            end
        end

        // R3 set beats clear
        wr(2'd1, 32'h2);
        evt = 31'h1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'h2;
        step();
        evt = '0; wr_en = 1'b0; wr_data = '0;
        chk("R3 set wins", stat, 32'h2);
        wr(2'd0, 32'h2);

        // R8 summary bit behaviour
        wr(2'd1, 32'h0010_8000);
        wr(2'd2, 32'h0000_8000);
        pulse(32'h0010_0000);
        step();
        chk("R8 summary set", stat, 32'h0010_8000);
        chk("R8 summary irq", {31'h0, irq}, 32'h1);
        wr(2'd0, 32'h0000_8000);
        chk("R8 clear ignored", stat, 32'h0010_8000);
        wr(2'd0, 32'h0010_0000);
        chk("R8 summary drops", stat, 32'h0);
        wr(2'd1, 32'h0000_8000);
        pulse(32'h0000_8000);
        chk("R8 event ignored", stat, 32'h0);

        // R7 buffer-ready wait for service
        for (int k = 0; k < 2; k++) begin
            wr(2'd1, 32'h1 << (4 + k));
            wr(2'd2, 32'h1 << (4 + k));
            pulse(32'h1 << (4 + k));
            chk("R7 first latch", stat, 32'h1 << (4 + k));
            wr(2'd0, 32'h1 << (4 + k));
            pulse(32'h1 << (4 + k));
            chk("R7 blocked until service", stat, 32'h0);
            step();
            chk("R7 no irq while waiting", {31'h0, irq}, 32'h0);
            svc = 2'(1 << k); step(); svc = '0;
            pulse(32'h1 << (4 + k));
            chk("R7 after service", stat, 32'h1 << (4 + k));
            wr(2'd0, 32'h1 << (4 + k));
            evt = 31'(32'h1 << (3 + k)); svc = 2'(1 << k);
            step();
            evt = '0; svc = '0;
            chk("R7 same-cycle service", stat, 32'h1 << (4 + k));
            wr(2'd0, 32'h1 << (4 + k));
            svc = 2'(1 << k); step(); svc = '0;
        end

        // R9 / R10 command complete
        wr(2'd1, 32'h0001_0001);
        wr(2'd2, 32'h0);
        busy = 1'b1; step();
        busy = 1'b0; step();
        chk("R9 cc on fall", stat, 32'h1);
        wr(2'd0, 32'h1);
        pulse(32'h1);
        chk("R9 no event input", stat, 32'h0);
        busy = 1'b1; step();
        pulse(32'h0001_0000);
        busy = 1'b0; step();
        chk("R10 cto in command", stat, 32'h0001_8000);
        wr(2'd0, 32'h0001_0000);
        busy = 1'b1; step();
        busy = 1'b0; evt = 31'h0000_8000; step(); evt = '0;
        chk("R10 cto at fall", stat, 32'h0001_8000);
        wr(2'd0, 32'h0001_0000);
        busy = 1'b1; step();
        busy = 1'b0; step();
        chk("R10 next command ok", stat, 32'h1);
        wr(2'd0, 32'h1);

        // R11 / R12 reserved bits and select 3
        wr(2'd1, 32'h0);
        wr(2'd3, 32'hFFFF_FFFF);
        chk("R12 select none en", en, 32'h0);
        chk("R12 select none mask", mask, 32'h0);
        wr(2'd1, 32'hFFFF_FFFF);
        chk("R11 en reserved", en, VALID);
        wr(2'd2, 32'hFFFF_FFFF);
        chk("R11 mask reserved", mask, VALID);
        pulse(32'hFFFF_FFFF);
        chk("R11 stat reserved", stat, VALID & ~32'h1);
        wr(2'd0, 32'hFFFF_FFFF);
        chk("R3 clear all", stat, 32'h0);

        done = 1'b1;
        report();
    end
endmodule